// File: doc/BRIEF.md
# Scanline Interrupt Counter Driven by a Pattern-Address Edge

This block raises a level interrupt after a programmable number of rendered lines. It does not count clocks. It watches the pattern-memory address bus, sampling it only on cycles when the access strobe is high, and treats a qualified low-to-high transition of address bit 12 as one line. A transition counts only when bit 12 was low on enough earlier strobed samples. This filter rejects the short bit-12 pulses that occur during ordinary fetches, so only the real once-per-line edge is taken.

The CPU programs the block with single writes into two 8 KiB windows near the top of its address space. Address bit 0 selects one of two actions in each window. In the lower window, an even address stores the reload value and an odd address arms a deferred reload. In the upper window, an even address turns the interrupt off and clears any request, and an odd address turns it on.

On a counted edge, the counter reloads from the stored value if a reload is armed or if the counter is already zero. Otherwise it steps down by one. If the counter is zero after this update and the interrupt is on, a request is latched. It stays latched until the CPU clears it.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write with address bits [15:13] = 3'b110 and address bit 0 = 0 stores the 8-bit data as the reload value, which the next reload uses.
- R2: A write with address bits [15:13] = 3'b110 and address bit 0 = 1 arms a reload. The next counted edge then loads the reload value, even if the counter is not zero, and disarms the reload.
- R3: A counted edge that finds the counter at zero loads the reload value.
- R4: A counted edge with no reload armed and a non-zero counter decrements the counter by one.
- R5: A strobed sample with bit 12 = 1 counts as an edge only if the previous strobed sample had bit 12 = 0 and at least 8 strobed low samples have occurred since reset or since the last counted edge. The low-sample tally saturates at 12 and is cleared only by a counted edge. An uncounted edge does not clear it.
- R6: The address bus has no effect on cycles when the pattern strobe is low.
- R7: If the counter is zero after a counted edge and the interrupt is enabled, irq_req is high from the clock edge that sampled the address. A reload value of 0 therefore requests on every counted edge.
- R8: A write with address bits [15:13] = 3'b111 and address bit 0 = 0 disables the interrupt and drops irq_req on the next clock edge. Until such a write occurs, irq_req stays high once it is set.
- R9: A write with address bits [15:13] = 3'b111 and address bit 0 = 1 enables the interrupt. A counted edge while the interrupt is disabled still updates the counter but raises no request.
- R10: Writes whose address bits [15:13] are not 3'b110 or 3'b111 have no effect.
- R11: After reset, irq_req is low. The counter, reload value, enable, armed reload and low-sample tally are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released after two clock edges |
| cpu_wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| pat_strobe | input | 1 | Pattern-memory access strobe; the address bus is sampled when this is high |
| pat_addr | input | 14 | Pattern-memory address bus |
| irq_req | output | 1 | Level interrupt request |

## Verification
Each CPU write and each strobed address sample takes effect at the clock edge where it is presented. A request raised by a counted edge, or dropped by the disable write, is therefore visible on irq_req in the following low clock phase. The reload value and the armed reload only show up on irq_req at a later counted edge. The bench drives one stimulus per cycle on the falling clock edge and samples irq_req on the next falling edge. It compares irq_req against a reference model stepped with the same stimulus. The directed sequences also count edges by hand, so the cycle in which the request must appear and disappear is checked explicitly.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_LATCH   = 3'd1,
    CMD_RELOAD  = 3'd2,
    CMD_DISABLE = 3'd3,
    CMD_ENABLE  = 3'd4
  } sirq_cmd_e;

  localparam logic [2:0] WIN_COUNT = 3'b110;
  localparam logic [2:0] WIN_IRQ   = 3'b111;
endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sirq_cpu_decode.sv
module sirq_cpu_decode
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output sirq_cmd_e         cmd,
  output logic [DATA_W-1:0] reload_val,
  output logic              irq_en
);
  logic [2:0]        win;
  logic [DATA_W-1:0] reload_d;
  logic              reload_ce;
  logic              en_d;
  logic              en_ce;

  assign win = addr[ADDR_W-1 -: 3];

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      if (win == WIN_COUNT) cmd = addr[0] ? CMD_RELOAD : CMD_LATCH;
      else if (win == WIN_IRQ) cmd = addr[0] ? CMD_ENABLE : CMD_DISABLE;
    end
  end

  always_comb begin
    reload_ce = (cmd == CMD_LATCH);
    reload_d  = wdata;
    en_ce     = (cmd == CMD_ENABLE) || (cmd == CMD_DISABLE);
    en_d      = (cmd == CMD_ENABLE);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      reload_val <= '0;
      irq_en     <= 1'b0;
    end else begin
      if (reload_ce) reload_val <= reload_d;
      if (en_ce)     irq_en     <= en_d;
    end
  end
endmodule

// File: rtl/sirq_edge_filter.sv
module sirq_edge_filter #(
  parameter int PAT_W    = 14,
  parameter int EDGE_BIT = 12,
  parameter int LOW_MIN  = 8,
  parameter int LOW_SAT  = 12,
  localparam int LOW_W   = $clog2(LOW_SAT + 1)
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             strobe,
  input  logic [PAT_W-1:0] pat_addr,
  output logic             edge_hit,
  output logic [LOW_W-1:0] low_cnt
);
  logic             line_now;
  logic             prev_q;
  logic             prev_d;
  logic [LOW_W-1:0] low_d;

  assign line_now = pat_addr[EDGE_BIT];

  always_comb begin
    edge_hit = strobe && line_now && !prev_q && (low_cnt >= LOW_W'(LOW_MIN));
    prev_d   = prev_q;
    low_d    = low_cnt;
    if (strobe) begin
      prev_d = line_now;
      if (edge_hit)
        low_d = '0;
      else if (!line_now && (low_cnt < LOW_W'(LOW_SAT)))
        low_d = low_cnt + LOW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prev_q  <= 1'b0;
      low_cnt <= '0;
    end else if (strobe) begin
      prev_q  <= prev_d;
      low_cnt <= low_d;
    end
  end
endmodule

// File: rtl/sirq_line_counter.sv
module sirq_line_counter
  import sirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             edge_hit,
  input  sirq_cmd_e        cmd,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             irq_en,
  output logic             pending
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             arm_q;
  logic             arm_d;
  logic             pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    arm_d  = arm_q;
    pend_d = pending;
    if (edge_hit) begin
      if (arm_q || (cnt_q == '0)) cnt_d = reload_val;
      else                        cnt_d = cnt_q - CNT_W'(1);
      arm_d = 1'b0;
      if ((cnt_d == '0) && irq_en) pend_d = 1'b1;
    end
    if (cmd == CMD_RELOAD)  arm_d  = 1'b1;
    if (cmd == CMD_DISABLE) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q   <= '0;
      arm_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (edge_hit) cnt_q <= cnt_d;
      arm_q   <= arm_d;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import sirq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PAT_W    = 14,
  parameter int EDGE_BIT = 12,
  parameter int LOW_MIN  = 8,
  parameter int LOW_SAT  = 12,
  localparam int LOW_W   = $clog2(LOW_SAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              pat_strobe,
  input  logic [PAT_W-1:0]  pat_addr,
  output logic              irq_req
);
  logic              srst_n;
  sirq_cmd_e         cmd;
  logic [DATA_W-1:0] reload_val;
  logic              irq_en;
  logic              edge_hit;
  logic [LOW_W-1:0]  low_cnt;

  sirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  sirq_cpu_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .srst_n(srst_n), .wr_en(cpu_wr_en), .addr(cpu_addr),
    .wdata(cpu_wdata), .cmd(cmd), .reload_val(reload_val), .irq_en(irq_en)
  );

  sirq_edge_filter #(
    .PAT_W(PAT_W), .EDGE_BIT(EDGE_BIT), .LOW_MIN(LOW_MIN), .LOW_SAT(LOW_SAT)
  ) u_flt (
    .clk(clk), .srst_n(srst_n), .strobe(pat_strobe), .pat_addr(pat_addr),
    .edge_hit(edge_hit), .low_cnt(low_cnt)
  );

  sirq_line_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .srst_n(srst_n), .edge_hit(edge_hit), .cmd(cmd),
    .reload_val(reload_val), .irq_en(irq_en), .pending(irq_req)
  );
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
  parameter int ADDR_W   = 16,
  parameter int PAT_W    = 14,
  parameter int EDGE_BIT = 12,
  parameter int LOW_SAT  = 12,
  parameter int LOW_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr_en,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              pat_strobe,
  input logic [PAT_W-1:0]  pat_addr,
  input logic              irq_req,
  input logic [LOW_W-1:0]  low_cnt
);
  logic ack_wr;
  assign ack_wr = cpu_wr_en && (cpu_addr[ADDR_W-1 -: 3] == 3'b111) && !cpu_addr[0];

  // R8
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> !irq_req);

  // R8
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ack_wr) |=> irq_req);

  // R6
  no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pat_strobe && !ack_wr) |=> $stable(irq_req));

  // R7
  irq_rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(pat_strobe && pat_addr[EDGE_BIT]));

  // R5
  low_tally_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= LOW_W'(LOW_SAT));
endmodule

bind scanline_irq_counter sirq_checker #(
  .ADDR_W(ADDR_W), .PAT_W(PAT_W), .EDGE_BIT(EDGE_BIT),
  .LOW_SAT(LOW_SAT), .LOW_W(LOW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
  .pat_strobe(pat_strobe), .pat_addr(pat_addr), .irq_req(irq_req),
  .low_cnt(low_cnt)
);

// File: tb/sim_scanline_irq_counter.sv
module sim_scanline_irq_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        pat_strobe = 1'b0;
  logic [13:0] pat_addr = '0;
  logic        irq_req;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_latch, m_cnt;
  logic       m_arm, m_en, m_pend, m_prev;
  int         m_low;

  always #10 clk = ~clk;

  scanline_irq_counter u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .pat_strobe(pat_strobe), .pat_addr(pat_addr),
    .irq_req(irq_req)
  );

  function automatic void model_reset();
    m_latch = 0; m_cnt = 0; m_arm = 0; m_en = 0; m_pend = 0; m_prev = 0; m_low = 0;
  endfunction

  function automatic void model_step(logic wr, logic [15:0] a, logic [7:0] d,
                                     logic stb, logic [13:0] pa);
    logic ln;
    logic hit;
    ln  = pa[12];
    hit = stb && ln && !m_prev && (m_low >= 8);
    if (hit) begin
      if (m_arm || m_cnt == 0) m_cnt = m_latch;
      else m_cnt = m_cnt - 8'd1;
      m_arm = 0;
      if (m_cnt == 0 && m_en) m_pend = 1;
      m_low = 0;
    end
    if (stb) begin
      m_prev = ln;
      if (!hit && !ln && m_low < 12) m_low++;
    end
    if (wr) begin
      if (a[15:13] == 3'b110) begin
        if (a[0]) m_arm = 1; else m_latch = d;
      end else if (a[15:13] == 3'b111) begin
        if (a[0]) m_en = 1; else begin m_en = 0; m_pend = 0; end
      end
    end
  endfunction

  task automatic check(logic exp, string tag);
    tests++;
    if (irq_req !== exp) begin
      fails++;
      $display("FAIL %s irq_req got %0b expected %0b at %0t", tag, irq_req, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, clock, compare with model at next negedge
  task automatic cyc(logic wr, logic [15:0] a, logic [7:0] d,
                     logic stb, logic [13:0] pa, string tag);
    cpu_wr_en = wr; cpu_addr = a; cpu_wdata = d; pat_strobe = stb; pat_addr = pa;
    @(posedge clk);
    model_step(wr, a, d, stb, pa);
    @(negedge clk);
    check(m_pend, tag);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
    cyc(1'b1, a, d, 1'b0, 14'h0, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 8'h0, 1'b0, 14'h0, tag);
  endtask

  task automatic line(int nlow, string tag);
    for (int i = 0; i < nlow; i++) cyc(1'b0, 16'h0, 8'h0, 1'b1, 14'h0040, tag);
    cyc(1'b0, 16'h0, 8'h0, 1'b1, 14'h1040, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    @(negedge clk);
    check(1'b0, "R11 reset");
    rst_n = 1'b1;
    idle(4, "R11");

    // R9 enable, R1 latch 3, R2 arm reload
    wr(16'hE001, 8'h00, "R9");
    wr(16'hC000, 8'h03, "R1");
    wr(16'hC001, 8'h00, "R2");
    line(8, "R2"); check(1'b0, "R2 reload to 3");
    line(8, "R4"); check(1'b0, "R4 3->2");
    line(8, "R4"); check(1'b0, "R4 2->1");
    line(8, "R7"); check(1'b1, "R7 1->0 raises");
    idle(3, "R8");
    line(3, "R8"); check(1'b1, "R8 holds");
    wr(16'hE000, 8'h00, "R8"); check(1'b0, "R8 ack drops");

    // R3: counted edge at zero reloads; R9 disabled edge gives no request
    line(8, "R9"); check(1'b0, "R9 disabled 0->3");
    wr(16'hE001, 8'h00, "R9");
    line(8, "R3"); line(8, "R3"); check(1'b0, "R3 at 1");
    line(8, "R3"); check(1'b1, "R3 reloaded then reached zero");
    wr(16'hE000, 8'h00, "R8"); wr(16'hE001, 8'h00, "R9");

    // R5 filter: 7 lows do not qualify; the tally is kept across the uncounted edge
    wr(16'hC000, 8'h01, "R1"); wr(16'hC001, 8'h00, "R2");
    line(8, "R5"); check(1'b0, "R5 reload to 1");
    line(7, "R5"); check(1'b0, "R5 short low rejected");
    line(1, "R5"); check(1'b1, "R5 tally carried");
    wr(16'hE000, 8'h00, "R8"); wr(16'hE001, 8'h00, "R9");

    // R6: high address without strobe is ignored
    wr(16'hC000, 8'h02, "R1"); wr(16'hC001, 8'h00, "R2");
    line(8, "R6"); check(1'b0, "R6 at 2");
    line(8, "R6"); check(1'b0, "R6 at 1");
    for (int i = 0; i < 10; i++) cyc(1'b0, 16'h0, 8'h0, 1'b0, 14'h0000, "R6");
    for (int i = 0; i < 3; i++) cyc(1'b0, 16'h0, 8'h0, 1'b0, 14'h1000, "R6");
    check(1'b0, "R6 unstrobed edge ignored");
    line(8, "R6"); check(1'b1, "R6 strobed edge counts");
    wr(16'hE000, 8'h00, "R8"); wr(16'hE001, 8'h00, "R9");

    // R10: out-of-window writes change nothing (latch stays 2)
    wr(16'h8000, 8'h00, "R10"); wr(16'hA001, 8'h09, "R10");
    wr(16'h6000, 8'h00, "R10"); wr(16'h4001, 8'h00, "R10");
    wr(16'hC001, 8'h00, "R2");
    line(8, "R10"); line(8, "R10"); check(1'b0, "R10 latch kept at 2");
    line(8, "R10"); check(1'b1, "R10 enable kept");
    wr(16'hE000, 8'h00, "R8"); wr(16'hE001, 8'h00, "R9");

    // R7 boundary: reload value 0 requests on every counted edge
    wr(16'hC000, 8'h00, "R1"); wr(16'hC001, 8'h00, "R2");
    line(8, "R7"); check(1'b1, "R7 latch zero");
    wr(16'hE000, 8'h00, "R8");
    wr(16'hE001, 8'h00, "R9");
    line(8, "R7"); check(1'b1, "R7 latch zero again");

    // constrained random against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8) begin
        logic [15:0] a;
        a = {3'b110 | 3'($urandom_range(0, 1)), 12'h0, 1'($urandom_range(0, 1))};
        if ($urandom_range(0, 9) == 0) a = 16'($urandom);
        cyc(1'b1, a, 8'($urandom_range(0, 4)), 1'b0, 14'h0, "R7 random");
      end else if (r < 85) begin
        logic [13:0] pa;
        pa = 14'($urandom);
        pa[12] = ($urandom_range(0, 9) == 0);
        cyc(1'b0, 16'h0, 8'h0, 1'b1, pa, "R5 random");
      end else begin
        cyc(1'b0, 16'h0, 8'h0, 1'b0, 14'($urandom), "R6 random");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule